// File: doc/BRIEF.md
# Machine-Cycle Timing State Sequencer

This block produces the internal timing frame of a small 8-bit controller core, running directly on the oscillator clock. Every machine cycle is cut into six states, and every state into two phases of one clock each, so one machine cycle takes twelve clocks. An instruction occupies one, two or four machine cycles. The sequencer keeps track of the active machine cycle. It issues one-hot state and phase indicators, and from fixed slots of that frame it derives the opcode fetch, decode and execute enables, the operand-byte fetch strobes and a pulse that marks the end of the instruction.

The instruction class comes from the opcode decoder and is captured once per instruction, at the end of the decode state. It carries a cycle-count code and a byte-count code. An idle request is looked at only on the instruction boundary. When it is honoured, the sequencer parks with every indicator low until the request is dropped, and then starts the next fetch.

Top module: `mcyc_seq`

## Requirements
- R1: Each state lasts two clocks: the first phase, then the second. `phase_oh` is one-hot while running, with bit 0 for the first phase and bit 1 for the second.
- R2: States run S1..S6 in order, one-hot on `state_oh` with bit i marking S(i+1). A machine cycle takes 12 clocks. `mcyc_idx` starts at 0 and steps by one after each S6 that is not the final one.
- R3: `opc_fetch` is high for exactly one clock, in the second phase of S1 of machine cycle 0. `decode_en` is high during both phases of S2 of machine cycle 0.
- R4: `len_mc` and `len_bytes` are captured on the clock in the second phase of S2 of machine cycle 0. Later changes have no effect on that instruction. `len_mc` 00 means 1 cycle, 01 means 2 cycles, and 10 or 11 means 4 cycles. `len_bytes` 0 or 1 means one byte, 2 means two bytes, 3 means three bytes.
- R5: `exec_en` is high from S3 of machine cycle 0 through S6 of the final machine cycle, so an instruction spans 12, 24 or 48 clocks.
- R6: `byte2_fetch` pulses in the second phase of S4 of machine cycle 0 when the captured byte code is 2 or 3.
- R7: `byte3_fetch` pulses in the second phase of S1 of machine cycle 1 when the captured byte code is 3 and the instruction has two or more cycles. It never fires for a one-cycle instruction.
- R8: `instr_end` is high in the second phase of S6 of the final machine cycle. Unless the sequencer goes idle, the next clock is the first phase of S1 of machine cycle 0.
- R9: `idle_req` is sampled only in the `instr_end` clock. If it is high there, then from the next clock all state, phase and strobe outputs are 0 and `mcyc_idx` is 0, and they stay so while `idle_req` stays high. The first clock with it low is followed by the first phase of S1.
- R10: A synchronous `rst` puts the sequencer in the first phase of S1 of machine cycle 0 with all fetch, decode, execute and end strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req | input | 1 | Idle / power-down request, sampled at the instruction boundary |
| len_mc | input | 2 | Machine-cycle count code of the current instruction |
| len_bytes | input | 2 | Byte count code of the current instruction |
| state_oh | output | 6 | One-hot state S1..S6, all zero when idle |
| phase_oh | output | 2 | One-hot phase, all zero when idle |
| mcyc_idx | output | 2 | Index of the active machine cycle |
| opc_fetch | output | 1 | Opcode fetch strobe |
| decode_en | output | 1 | Decode enable |
| exec_en | output | 1 | Execute enable |
| byte2_fetch | output | 1 | Second-byte fetch strobe |
| byte3_fetch | output | 1 | Third-byte fetch strobe |
| instr_end | output | 1 | Instruction boundary pulse |

## Verification
The class inputs are scrambled on every clock, so a design that read them live instead of from its capture in S2 would stretch or cut instructions and land its boundary pulse in the wrong clock. Three-byte one-cycle codes are driven on purpose, and a design that ignored the cycle-count condition would emit a stray third-byte strobe on them. Idle requests are raised in the middle of instructions as well as on the boundary. A design that honoured them mid-instruction would freeze early, and one that resumed late would shift every later slot. A reset in the middle of a long instruction checks that the multi-cycle counter and the captured length are cleared together.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int unsigned N_ST  = 6;
    localparam int unsigned ST_W  = $clog2(N_ST);
    localparam int unsigned MC_W  = 2;
    localparam int unsigned BY_W  = 2;

    // Fixed slots within the frame (state index, 0 = S1)
    localparam int unsigned SL_FETCH  = 0;
    localparam int unsigned SL_DECODE = 1;
    localparam int unsigned SL_EXEC0  = 2;
    localparam int unsigned SL_BYTE2  = 3;
    localparam int unsigned SL_BYTE3  = 0;

    typedef struct packed {
        logic            run;
        logic            ph;
        logic [ST_W-1:0] st;
        logic [MC_W-1:0] mc;
        logic [MC_W-1:0] last_mc;
        logic [BY_W-1:0] nbytes;
    } seq_t;

    // Cycle-count code to index of the final machine cycle
    function automatic logic [MC_W-1:0] last_of(input logic [1:0] code);
        case (code)
            2'b00:   return MC_W'(0);
            2'b01:   return MC_W'(1);
            default: return MC_W'(3);
        endcase
    endfunction
endpackage

// File: rtl/mcs_counter.sv
module mcs_counter
    import mcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            idle_req,
    input  logic [1:0]      len_mc,
    input  logic [BY_W-1:0] len_bytes,
    output seq_t            q
);
    localparam logic [ST_W-1:0] ST_LAST = ST_W'(N_ST - 1);
    localparam logic [ST_W-1:0] ST_CAP  = ST_W'(SL_DECODE);

    seq_t seq_d, seq_q;
    logic at_end;
    logic capture;

    always_comb begin
        seq_d   = seq_q;
        at_end  = seq_q.run && seq_q.ph && (seq_q.st == ST_LAST)
                  && (seq_q.mc == seq_q.last_mc);
        capture = seq_q.run && seq_q.ph && (seq_q.st == ST_CAP)
                  && (seq_q.mc == '0);

        if (!seq_q.run) begin
            if (!idle_req) begin
                seq_d.run = 1'b1;
                seq_d.ph  = 1'b0;
                seq_d.st  = '0;
                seq_d.mc  = '0;
            end
        end else begin
            seq_d.ph = ~seq_q.ph;
            if (seq_q.ph) begin
                if (seq_q.st == ST_LAST) begin
                    seq_d.st = '0;
                    seq_d.mc = at_end ? '0 : seq_q.mc + 1'b1;
                end else begin
                    seq_d.st = seq_q.st + 1'b1;
                end
            end
            if (capture) begin
                seq_d.last_mc = last_of(len_mc);
                seq_d.nbytes  = len_bytes;
            end
            if (at_end && idle_req) begin
                seq_d.run = 1'b0;
                seq_d.ph  = 1'b0;
                seq_d.st  = '0;
                seq_d.mc  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.run     <= 1'b1;
            seq_q.ph      <= 1'b0;
            seq_q.st      <= '0;
            seq_q.mc      <= '0;
            seq_q.last_mc <= '0;
            seq_q.nbytes  <= BY_W'(1);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign q = seq_q;
endmodule

// File: rtl/mcs_strobes.sv
module mcs_strobes
    import mcs_pkg::*;
(
    input  seq_t            q,
    output logic [N_ST-1:0] state_oh,
    output logic [1:0]      phase_oh,
    output logic [MC_W-1:0] mcyc_idx,
    output logic            opc_fetch,
    output logic            decode_en,
    output logic            exec_en,
    output logic            byte2_fetch,
    output logic            byte3_fetch,
    output logic            instr_end
);
    logic first_mc;
    logic second_mc;

    genvar gi;
    generate
        for (gi = 0; gi < N_ST; gi++) begin : g_state
            assign state_oh[gi] = q.run && (q.st == ST_W'(gi));
        end
    endgenerate

    always_comb begin
        first_mc    = (q.mc == '0);
        second_mc   = (q.mc == MC_W'(1));
        phase_oh    = q.run ? (q.ph ? 2'b10 : 2'b01) : 2'b00;
        mcyc_idx    = q.run ? q.mc : '0;
        opc_fetch   = state_oh[SL_FETCH]  && q.ph && first_mc;
        decode_en   = state_oh[SL_DECODE] && first_mc;
        exec_en     = q.run && !(first_mc && (q.st < ST_W'(SL_EXEC0)));
        byte2_fetch = state_oh[SL_BYTE2] && q.ph && first_mc
                      && (q.nbytes >= BY_W'(2));
        byte3_fetch = state_oh[SL_BYTE3] && q.ph && second_mc
                      && (q.nbytes == BY_W'(3)) && (q.last_mc != '0);
        instr_end   = state_oh[N_ST-1] && q.ph && (q.mc == q.last_mc);
    end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
    import mcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            idle_req,
    input  logic [1:0]      len_mc,
    input  logic [BY_W-1:0] len_bytes,
    output logic [N_ST-1:0] state_oh,
    output logic [1:0]      phase_oh,
    output logic [MC_W-1:0] mcyc_idx,
    output logic            opc_fetch,
    output logic            decode_en,
    output logic            exec_en,
    output logic            byte2_fetch,
    output logic            byte3_fetch,
    output logic            instr_end
);
    seq_t cur;

    mcs_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .idle_req  (idle_req),
        .len_mc    (len_mc),
        .len_bytes (len_bytes),
        .q         (cur)
    );

    mcs_strobes u_strb (
        .q           (cur),
        .state_oh    (state_oh),
        .phase_oh    (phase_oh),
        .mcyc_idx    (mcyc_idx),
        .opc_fetch   (opc_fetch),
        .decode_en   (decode_en),
        .exec_en     (exec_en),
        .byte2_fetch (byte2_fetch),
        .byte3_fetch (byte3_fetch),
        .instr_end   (instr_end)
    );
endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk
    import mcs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            idle_req,
    input logic [1:0]      len_mc,
    input logic [BY_W-1:0] len_bytes,
    input logic [N_ST-1:0] state_oh,
    input logic [1:0]      phase_oh,
    input logic [MC_W-1:0] mcyc_idx,
    input logic            opc_fetch,
    input logic            decode_en,
    input logic            exec_en,
    input logic            byte2_fetch,
    input logic            byte3_fetch,
    input logic            instr_end
);
    assert_state_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(state_oh) && ($countones(state_oh) == $countones(phase_oh)));

    assert_phase_order_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_oh == 2'b01) |=> (phase_oh == 2'b10) && $stable(state_oh));

    assert_fetch_then_decode_R3: assert property (@(posedge clk) disable iff (rst)
        opc_fetch |=> decode_en && (phase_oh == 2'b01));

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (instr_end && !idle_req) |=> (state_oh == 6'b000001) && (phase_oh == 2'b01)
                                     && (mcyc_idx == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_oh == 2'b00) |-> !(opc_fetch || decode_en || exec_en || byte2_fetch
                                  || byte3_fetch || instr_end) && (mcyc_idx == '0));

    assert_no_mid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        ((phase_oh != 2'b00) && !instr_end) |=> (phase_oh != 2'b00));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (state_oh == 6'b000001) && (phase_oh == 2'b01) && !opc_fetch
                && !exec_en && !instr_end);
endmodule

bind mcyc_seq mcyc_seq_chk chk_i (.*);

// File: tb/mcyc_seq_tb_top.sv
module mcyc_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idle_req = 1'b0;
    logic [1:0] len_mc = 2'b00;
    logic [1:0] len_bytes = 2'b01;
    logic [5:0] state_oh;
    logic [1:0] phase_oh;
    logic [1:0] mcyc_idx;
    logic       opc_fetch, decode_en, exec_en, byte2_fetch, byte3_fetch, instr_end;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model: position k within the instruction, clocks since fetch start
    bit m_run = 1'b1;
    int m_k   = 0;
    int m_n   = 1;
    int m_b   = 1;

    always #5 clk = ~clk;

    mcyc_seq dut_i (
        .clk(clk), .rst(rst), .idle_req(idle_req), .len_mc(len_mc),
        .len_bytes(len_bytes), .state_oh(state_oh), .phase_oh(phase_oh),
        .mcyc_idx(mcyc_idx), .opc_fetch(opc_fetch), .decode_en(decode_en),
        .exec_en(exec_en), .byte2_fetch(byte2_fetch), .byte3_fetch(byte3_fetch),
        .instr_end(instr_end)
    );

    function automatic int cycles_of(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic check_outputs();
        int es, ep, em;
        bit ef, ed, ex, e2, e3, ee;
        es = m_run ? (1 << ((m_k / 2) % 6)) : 0;
        ep = m_run ? (1 << (m_k % 2)) : 0;
        em = m_run ? (m_k / 12) : 0;
        ef = m_run && (m_k == 1);
        ed = m_run && (m_k == 2 || m_k == 3);
        ex = m_run && (m_k >= 4);
        e2 = m_run && (m_k == 7) && (m_b >= 2);
        e3 = m_run && (m_k == 13) && (m_b == 3) && (m_n >= 2);
        ee = m_run && (m_k == 12 * m_n - 1);
        chk(int'(phase_oh) == ep, m_run ? "R1" : "R9", int'(phase_oh), ep);
        chk(int'(state_oh) == es, m_run ? "R2" : "R9", int'(state_oh), es);
        chk(int'(mcyc_idx) == em, "R2", int'(mcyc_idx), em);
        chk(opc_fetch == ef, "R3", int'(opc_fetch), int'(ef));
        chk(decode_en == ed, "R3", int'(decode_en), int'(ed));
        chk(exec_en == ex, "R5", int'(exec_en), int'(ex));
        chk(byte2_fetch == e2, "R6", int'(byte2_fetch), int'(e2));
        chk(byte3_fetch == e3, "R7", int'(byte3_fetch), int'(e3));
        chk(instr_end == ee, "R8", int'(instr_end), int'(ee));
    endtask

    // advance the model across the coming rising edge, using the inputs now driven
    task automatic step_model();
        if (rst) begin
            m_run = 1'b1; m_k = 0; m_n = 1; m_b = 1;
        end else if (!m_run) begin
            if (!idle_req) begin m_run = 1'b1; m_k = 0; end
        end else if (m_k == 12 * m_n - 1) begin
            m_k = 0;
            if (idle_req) m_run = 1'b0;
        end else begin
            if (m_k == 3) begin              // R4 capture slot
                m_n = cycles_of(len_mc);
                m_b = int'(len_bytes);
            end
            m_k++;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) begin
            @(negedge clk);
            step_model();
        end
        // R10: reset state
        @(negedge clk);
        check_outputs();
        rst = 1'b0;
        step_model();
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            check_outputs();
            rst      = (cyc >= 3000 && cyc < 3002);     // R10 mid-run reset
            len_mc   = 2'($urandom);                     // R4 scrambled every clock
            len_bytes = 2'($urandom);
            if (cyc < 200)                               // directed: three-byte one-cycle
                begin len_mc = 2'b00; len_bytes = 2'b11; end
            else if (cyc >= 1000 && cyc < 1040)          // directed long idle
                idle_req = 1'b1;
            else
                idle_req = ($urandom % 4) == 0;          // R9 random, incl. mid-instruction
            step_model();
        end
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule